// File: doc/BRIEF.md
# Latched-Select Registered Eight-Way Selector

This block picks one bit out of a group of data inputs and presents it on two complementary outputs that can float, so that several such selectors can share one wire. Both the channel number and the data word sit behind storage. The channel number is held by a level-controlled hold stage. The data word is held by a stage that a build-time parameter sets to one of two kinds. One kind is level-controlled and behaves like the channel-number stage. The other kind captures the word when a strobe input rises.

Inside the chip all storage runs on the system clock `clk` with a synchronous active-low reset. A level-controlled stage is built from a register plus a bypass. While the stage is open, the output follows its input within the same cycle, and the register copies the input at every clock edge. While the stage is closed, the output shows the copy taken at the last edge at which the stage was still open. In the edge-capture kind, `dstore` is sampled by `clk`. A rising edge is a sample of 1 that follows a sample of 0, and it loads the data word at that clock edge.

Top module: `lsel_mux8`

## Requirements
- R1: While the outputs are enabled, `y_out` equals bit k of the effective data word, where k is the effective select value read as an unsigned binary number and bit k of `d_in` is channel k.
- R2: While `sel_hold` is 0, the effective select equals `sel_in` in the same cycle, and the stored select copies `sel_in` at every clock edge.
- R3: While `sel_hold` is 1, the effective select is the value stored at the last clock edge at which `sel_hold` was 0, and changes on `sel_in` have no effect on the outputs.
- R4: With `STORE_MODE = STORE_LATCH`, the data stage is transparent while `dstore` is 0. While `dstore` is 1, it holds the word stored at the last clock edge at which `dstore` was 0.
- R5: With `STORE_MODE = STORE_FLOP`, the data word is loaded from `d_in` only at a clock edge where `dstore` is sampled 1 after a sample of 0. The new bit appears on the outputs after that edge and not before. At every other edge the word is unchanged.
- R6: While the outputs are enabled, `w_out` is the exact inverse of `y_out`.
- R7: The outputs are enabled only when `oe_a_n` = 0, `oe_b_n` = 0 and `oe_c` = 1. Under any other combination both `y_out` and `w_out` are high-impedance.
- R8: A clock edge with `rst_n` = 0 clears the stored select and the stored data word to 0. It also records the previous `dstore` sample as 1, so a `dstore` that is already high when reset is released loads nothing.
- R9: With `sel_hold` = 0 and, in the level-controlled kind, `dstore` = 0, the outputs follow `d_in` and `sel_in` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| d_in | input | NUM_CH | Data channels, bit k is channel k |
| sel_in | input | SEL_W | Binary channel number |
| sel_hold | input | 1 | 1 closes the select stage, 0 opens it |
| dstore | input | 1 | Data stage control: hold level (latch kind) or capture strobe (flop kind) |
| oe_a_n | input | 1 | Output enable, active low |
| oe_b_n | input | 1 | Output enable, active low |
| oe_c | input | 1 | Output enable, active high |
| y_out | output | 1 | Selected bit, or high-impedance |
| w_out | output | 1 | Inverse of selected bit, or high-impedance |

## Verification
The bench builds two copies with the default eight channels and drives both from the same inputs. `uut` uses `STORE_LATCH` and `uut_ff` uses `STORE_FLOP`. This lets each stimulus compare transparent data against strobed data, including the case where `dstore` is high when reset is released. Each output wire also carries a weak-intent bench driver that pulls it to 0 only when the outputs should float. Any drive from the block while it should float therefore shows up as a 1 on one of the two wires.

// File: rtl/lsm_pkg.sv
// Package: shared types for the latched-select selector.
// Assumes nothing beyond IEEE 1800-2017.
package lsm_pkg;
    // Kind of storage used for the data word.
    typedef enum logic {
        STORE_LATCH = 1'b0,
        STORE_FLOP  = 1'b1
    } store_mode_e;
endpackage

// File: rtl/lsm_level_hold.sv
// Module: level-controlled hold stage built as register plus bypass.
// While hold is 0 the output follows d and the register copies d at each edge.
// While hold is 1 the output shows the copy from the last open edge.
// Assumes inputs are synchronous to clk.
module lsm_level_hold #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_eff
);
    logic [W-1:0] q_reg;

    // Keep a copy of the input whenever the stage is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_reg <= RST_VAL;
        else if (!hold)
            q_reg <= d;
    end

    // Transparent path while open, stored copy while closed.
    always_comb begin
        q_eff = hold ? q_reg : d;
    end

    // R3 for the select stage, R4 when used as the data stage.
    p_closed_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && hold && $past(hold)) |-> $stable(q_eff));
endmodule

// File: rtl/lsm_edge_capture.sv
// Module: strobe-captured storage for the data word.
// Samples the strobe with clk and loads d at the edge where a 1 follows a 0.
// Assumes the strobe is synchronous to clk; after reset the previous sample reads as 1.
module lsm_edge_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic strobe_prev;
    logic rise;

    // Detect a rising strobe relative to the previous sample.
    always_comb begin
        rise = strobe & ~strobe_prev;
    end

    // Remember the strobe and load the word on a rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_prev <= 1'b1;
            q           <= '0;
        end else begin
            strobe_prev <= strobe;
            if (rise)
                q <= d;
        end
    end

    // R5: a rise loads the word presented at that edge.
    p_capture_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rise)) |-> (q == $past(d)));

    // R5: without a rise the word does not move.
    p_no_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rise)) |-> $stable(q));
endmodule

// File: rtl/lsm_data_stage.sv
// Module: data word storage; the parameter picks level hold or strobe capture.
// Assumes dstore is synchronous to clk.
module lsm_data_stage
    import lsm_pkg::*;
#(
    parameter int          W          = 8,
    parameter store_mode_e STORE_MODE = STORE_LATCH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dstore,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STORE_MODE == STORE_LATCH) begin : g_level
            // Level kind: dstore high holds, low passes.
            lsm_level_hold #(.W(W), .RST_VAL('0)) u_hold (
                .clk   (clk),
                .rst_n (rst_n),
                .hold  (dstore),
                .d     (d),
                .q_eff (q)
            );
        end else begin : g_edge
            // Edge kind: dstore rising loads the word.
            lsm_edge_capture #(.W(W)) u_cap (
                .clk    (clk),
                .rst_n  (rst_n),
                .strobe (dstore),
                .d      (d),
                .q      (q)
            );
        end
    endgenerate
endmodule

// File: rtl/lsm_decode_pick.sv
// Module: full binary decode of the channel number and AND-OR pick of one bit.
// Assumes NUM_CH is a power of two so every code names a channel.
module lsm_decode_pick #(
    parameter int NUM_CH = 8,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_CH-1:0] data,
    output logic              pick
);
    logic [NUM_CH-1:0] dec;

    // One decode line per channel.
    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
            assign dec[k] = (sel == SEL_W'(k));
        end
    endgenerate

    // Gate the word with the decode lines and merge.
    always_comb begin
        pick = |(dec & data);
    end

    // R1: the decode names exactly one channel.
    p_single_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dec) == 1);
endmodule

// File: rtl/lsel_mux8.sv
// Module: latched-select selector with stored data and complementary float-capable outputs.
// Select storage is always level-controlled; data storage kind is set by STORE_MODE.
// Assumes all inputs are synchronous to clk and NUM_CH is a power of two.
module lsel_mux8
    import lsm_pkg::*;
#(
    parameter int          NUM_CH     = 8,
    parameter store_mode_e STORE_MODE = STORE_LATCH,
    localparam int         SEL_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] d_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              sel_hold,
    input  logic              dstore,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  logic              oe_c,
    output logic              y_out,
    output logic              w_out
);
    logic [SEL_W-1:0]  sel_eff;
    logic [NUM_CH-1:0] data_eff;
    logic              pick;
    logic              oe_on;

    // Select path: level hold stage.
    lsm_level_hold #(.W(SEL_W), .RST_VAL('0)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (sel_hold),
        .d     (sel_in),
        .q_eff (sel_eff)
    );

    // Data path: storage kind chosen by parameter.
    lsm_data_stage #(.W(NUM_CH), .STORE_MODE(STORE_MODE)) u_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .dstore (dstore),
        .d      (d_in),
        .q      (data_eff)
    );

    // Decode and pick the addressed bit.
    lsm_decode_pick #(.NUM_CH(NUM_CH)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel_eff),
        .data  (data_eff),
        .pick  (pick)
    );

    // All three enable terms must agree before anything is driven.
    always_comb begin
        oe_on = ~oe_a_n & ~oe_b_n & oe_c;
    end

    // Complementary outputs that float together.
    assign y_out = oe_on ? pick  : 1'bz;
    assign w_out = oe_on ? ~pick : 1'bz;
endmodule

// File: tb/lsel_mux8_test.sv
module lsel_mux8_test;
    import lsm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] d_in;
    logic [2:0]     sel_in;
    logic           sel_hold, dstore, oe_a_n, oe_b_n, oe_c;
    logic           park;
    wire            y_l, w_l, y_f, w_f;

    int checks = 0;
    int errors = 0;

    // Reference state, updated from the requirements.
    logic [2:0]     m_sel;
    logic [NCH-1:0] m_lat, m_ff;
    logic           m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench pulls the wires low only when the block should float (R7).
    assign y_l = park ? 1'b0 : 1'bz;
    assign w_l = park ? 1'b0 : 1'bz;
    assign y_f = park ? 1'b0 : 1'bz;
    assign w_f = park ? 1'b0 : 1'bz;

    lsel_mux8 #(.NUM_CH(NCH), .STORE_MODE(STORE_LATCH)) uut (
        .clk(clk), .rst_n(rst_n), .d_in(d_in), .sel_in(sel_in),
        .sel_hold(sel_hold), .dstore(dstore), .oe_a_n(oe_a_n),
        .oe_b_n(oe_b_n), .oe_c(oe_c), .y_out(y_l), .w_out(w_l));

    lsel_mux8 #(.NUM_CH(NCH), .STORE_MODE(STORE_FLOP)) uut_ff (
        .clk(clk), .rst_n(rst_n), .d_in(d_in), .sel_in(sel_in),
        .sel_hold(sel_hold), .dstore(dstore), .oe_a_n(oe_a_n),
        .oe_b_n(oe_b_n), .oe_c(oe_c), .y_out(y_f), .w_out(w_f));

    function automatic logic exp_bit(input logic [NCH-1:0] word, input logic [2:0] s);
        return word[s];
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, advance the model at posedge, compare shortly after.
    task automatic step(input logic r, input logic [NCH-1:0] d, input logic [2:0] s,
                        input logic h, input logic ds, input logic an, input logic bn,
                        input logic c, input string tag);
        logic       en;
        logic [2:0] se;
        logic       bl, bf;
        @(negedge clk);
        rst_n = r; d_in = d; sel_in = s; sel_hold = h; dstore = ds;
        oe_a_n = an; oe_b_n = bn; oe_c = c;
        park = !(!an && !bn && c);
        @(posedge clk);
        if (!r) begin
            m_sel = '0; m_lat = '0; m_ff = '0; m_prev = 1'b1;   // R8
        end else begin
            if (!h)  m_sel = s;
            if (!ds) m_lat = d;
            if (!m_prev && ds) m_ff = d;
            m_prev = ds;
        end
        #1;
        en = !an && !bn && c;
        se = h ? m_sel : s;
        bl = exp_bit(ds ? m_lat : d, se);
        bf = exp_bit(m_ff, se);
        if (en) begin
            chk(tag,  "y latch", y_l, bl);
            chk("R6", "w latch", w_l, ~bl);
            chk(tag,  "y flop",  y_f, bf);
            chk("R6", "w flop",  w_f, ~bf);
        end else begin
            chk("R7", "y latch float", y_l, 1'b0);
            chk("R7", "w latch float", w_l, 1'b0);
            chk("R7", "y flop float",  y_f, 1'b0);
            chk("R7", "w flop float",  w_f, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2718);
        park = 1'b0;
        rst_n = 1'b0; d_in = '0; sel_in = '0; sel_hold = 1'b1; dstore = 1'b1;
        oe_a_n = 1'b0; oe_b_n = 1'b0; oe_c = 1'b1;

        // R8: reset clears storage; strobe already high gives no load after release.
        step(1'b0, 8'hFF, 3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(1'b0, 8'hFF, 3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(1'b1, 8'hFF, 3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(1'b1, 8'hFF, 3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");

        // R9 and R2: both stages open, sweep every channel.
        for (int k = 0; k < NCH; k++)
            step(1'b1, 8'hA5, 3'(k), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
        for (int k = 0; k < NCH; k++)
            step(1'b1, 8'h3C, 3'(k), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");

        // R3: close select on channel 5, then move sel_in.
        step(1'b1, 8'b0010_0000, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
        step(1'b1, 8'b0010_0000, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
        step(1'b1, 8'b0010_0000, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3");

        // R4: close data stage on 0x20, then change d_in.
        step(1'b1, 8'b0010_0000, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        step(1'b1, 8'h00,        3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        step(1'b1, 8'hDF,        3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R4");

        // R5: strobe low, then rise with new word, then change while high.
        step(1'b1, 8'h00, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b1, 8'h20, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b1, 8'h00, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b1, 8'h00, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");

        // R7: every enable combination.
        for (int k = 0; k < 8; k++)
            step(1'b1, 8'h96, 3'(k), 1'b0, 1'b0, k[0], k[1], k[2], "R7");

        // R1: random traffic against the reference model.
        for (int k = 0; k < 600; k++) begin
            logic [NCH-1:0] rd;
            logic [2:0]     rs;
            logic           rh, rds, ren;
            rd  = NCH'($urandom);
            rs  = 3'($urandom);
            rh  = ($urandom % 3) != 0;
            rds = ($urandom % 2) != 0;
            ren = ($urandom % 4) != 0;
            if (ren)
                step(1'b1, rd, rs, rh, rds, 1'b0, 1'b0, 1'b1, "R1");
            else
                step(1'b1, rd, rs, rh, rds, 1'($urandom), 1'($urandom), 1'($urandom), "R1");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule